// File: doc/BRIEF.md
# Processor Bus Status Capture and Buffer Gating

This block sits between an 8-bit processor that multiplexes a status byte onto its data bus and the system backplane. At the start of every machine cycle the processor drives eight status flags on the data bus while it raises its cycle-start strobe. The block captures that byte during the phase-1 window and presents it, unchanged, for the rest of the machine cycle. The backplane uses it to tell a fetch from a memory read, an I/O transfer, a stack access, a halt or an interrupt acknowledge.

The block also decides when the incoming-data buffers may drive the processor. They open only while the processor is reading the bus or has granted a hold, and only while the front panel allows execution, either free running or stepping. A sense-switch read overrides them: during an input cycle addressed to the switch port, the buffers stay closed so that the switch values can be placed on the bus directly. The external ready and hold requests are resynchronised and then advanced only on the phase-2 strobe, so the processor never sees them move inside phase 2. Each of the four output driver groups has its own disable line that turns its enable off.

The design runs on a single system clock. Phase 1 and phase 2 arrive as one-cycle enable strobes.

Top module: `cpu_bus_glue`

## Requirements
- R1: On a clock edge where `cpu_sync` and `ph1_stb` are both high, `status_q` takes the value on `cpu_data` and shows it from the next cycle onward. Bit positions: 0 interrupt acknowledge, 1 write/output, 2 stack, 3 halt acknowledge, 4 output, 5 opcode fetch, 6 input, 7 memory read.
- R2: On every other edge `status_q` keeps its value, whatever `cpu_data`, `cpu_sync` alone or `ph1_stb` alone do.
- R3: `din_en` is high exactly when (`cpu_dbin` or `cpu_hlda`) and (`run_mode` or `step_mode`) are true and `ssw_dis` is low.
- R4: `ssw_dis` is high exactly when the latched input flag (`status_q` bit 6) is set and `io_port` equals the sense-switch port (default 8'hFF).
- R5: `ready_sync` and `hold_sync` pass through a two-flop synchroniser. On an edge with `ph2_stb` high they take the synchronised value, which is the request level sampled two edges earlier.
- R6: On edges with `ph2_stb` low, `ready_sync` and `hold_sync` do not change.
- R7: `group_oe[i]` equals the inverse of `group_dis[i]`, with group bits 0 address, 1 data out, 2 status, 3 command/control.
- R8: While `rst_n` is low, `status_q`, `ready_sync` and `hold_sync` are zero. After release the registers stay cleared for two more clock edges, and the first functional edge is the third one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1_stb | input | 1 | One-cycle phase-1 strobe |
| ph2_stb | input | 1 | One-cycle phase-2 leading-edge strobe |
| cpu_sync | input | 1 | Processor machine-cycle start strobe |
| cpu_dbin | input | 1 | Processor reading the data bus |
| cpu_hlda | input | 1 | Processor hold acknowledge |
| cpu_data | input | 8 | Processor bidirectional data bus as observed |
| io_port | input | 8 | Low address byte, the I/O device number |
| run_mode | input | 1 | Front panel: running |
| step_mode | input | 1 | Front panel: single step in progress |
| ext_ready | input | 1 | Asynchronous ready request from the backplane |
| ext_hold | input | 1 | Asynchronous hold request from the backplane |
| group_dis | input | 4 | Per-group driver disables |
| status_q | output | 8 | Latched status byte |
| din_en | output | 1 | Incoming-data buffer enable |
| ssw_dis | output | 1 | Sense-switch override of the input buffers |
| ready_sync | output | 1 | Ready, aligned to phase 2 |
| hold_sync | output | 1 | Hold, aligned to phase 2 |
| group_oe | output | 4 | Per-group driver enables |

## Verification
The assertions check on every cycle that a capture loads the bus value and that no other edge disturbs the latch. They also check that the buffer enable never rises without a bus read or hold grant and an execution mode, or while the sense-switch override is active. Further per-cycle checks cover the override's dependence on the input flag and port number, the stillness of ready and hold outside phase 2, the group enables, and the cleared state under reset. Two things only the bench's scenarios can show: the exact two-edge lag of the request synchroniser, and the two-edge delay before the first capture after reset. Both rest on a cycle-by-cycle reference model driven with varied phase patterns, stray strobes and a bus that changes every cycle.

// File: rtl/cpu_glue_pkg.sv
package cpu_glue_pkg;

  // Status byte bit positions as driven by the processor.
  localparam int SB_INT_ACK  = 0;
  localparam int SB_WR_OUT   = 1;
  localparam int SB_STACK    = 2;
  localparam int SB_HALT_ACK = 3;
  localparam int SB_OUT      = 4;
  localparam int SB_FETCH    = 5;
  localparam int SB_INP      = 6;
  localparam int SB_MEM_RD   = 7;
  localparam int STAT_W      = 8;

  // Output driver groups.
  localparam int GRP_ADDR = 0;
  localparam int GRP_DOUT = 1;
  localparam int GRP_STAT = 2;
  localparam int GRP_CMD  = 3;
  localparam int NUM_GRP  = 4;

  typedef struct packed {
    logic mem_rd;
    logic inp;
    logic fetch;
    logic out;
    logic halt_ack;
    logic stack;
    logic wr_out;
    logic int_ack;
  } status_t;

endpackage

// File: rtl/glue_rst_sync.sv
module glue_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_out_n = sh_q[STAGES-1];
endmodule

// File: rtl/glue_status_latch.sv
module glue_status_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] bus_d,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (cap_en) stat_nxt = bus_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end
endmodule

// File: rtl/glue_req_sync.sv
module glue_req_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [WIDTH-1:0] req_in,
  output logic [WIDTH-1:0] req_out
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] out_nxt;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_nxt;
    if (s == 0) begin : g_first
      always_comb stg_nxt = req_in;
    end else begin : g_rest
      always_comb stg_nxt = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= stg_nxt;
    end
  end

  always_comb begin
    out_nxt = req_out;
    if (adv_en) out_nxt = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_out <= '0;
    else        req_out <= out_nxt;
  end
endmodule

// File: rtl/glue_input_gate.sv
module glue_input_gate #(
  parameter int          PORT_W     = 8,
  parameter logic [7:0]  SENSE_PORT = 8'hFF
) (
  input  logic              bus_rd,
  input  logic              hold_ack,
  input  logic              run_mode,
  input  logic              step_mode,
  input  logic              inp_flag,
  input  logic [PORT_W-1:0] io_port,
  output logic              din_en,
  output logic              ssw_dis
);
  localparam logic [PORT_W-1:0] PORT_MATCH = PORT_W'(SENSE_PORT);

  logic proc_wants;
  logic panel_lets;

  always_comb begin
    ssw_dis    = inp_flag && (io_port == PORT_MATCH);
    proc_wants = bus_rd || hold_ack;
    panel_lets = run_mode || step_mode;
    din_en     = proc_wants && panel_lets && !ssw_dis;
  end
endmodule

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue
  import cpu_glue_pkg::*;
#(
  parameter int         DATA_W      = STAT_W,
  parameter int         PORT_W      = 8,
  parameter logic [7:0] SENSE_PORT  = 8'hFF,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ph1_stb,
  input  logic               ph2_stb,
  input  logic               cpu_sync,
  input  logic               cpu_dbin,
  input  logic               cpu_hlda,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic [PORT_W-1:0]  io_port,
  input  logic               run_mode,
  input  logic               step_mode,
  input  logic               ext_ready,
  input  logic               ext_hold,
  input  logic [NUM_GRP-1:0] group_dis,
  output logic [DATA_W-1:0]  status_q,
  output logic               din_en,
  output logic               ssw_dis,
  output logic               ready_sync,
  output logic               hold_sync,
  output logic [NUM_GRP-1:0] group_oe
);
  localparam int REQ_W = 2;

  logic             rst_int_n;
  logic             cap_en;
  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_al;

  glue_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  assign cap_en = cpu_sync && ph1_stb;

  glue_status_latch #(.W(DATA_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .bus_d  (cpu_data),
    .stat_q (status_q)
  );

  glue_input_gate #(.PORT_W(PORT_W), .SENSE_PORT(SENSE_PORT)) u_gate (
    .bus_rd    (cpu_dbin),
    .hold_ack  (cpu_hlda),
    .run_mode  (run_mode),
    .step_mode (step_mode),
    .inp_flag  (status_q[SB_INP]),
    .io_port   (io_port),
    .din_en    (din_en),
    .ssw_dis   (ssw_dis)
  );

  assign req_raw = {ext_hold, ext_ready};

  glue_req_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_req (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adv_en  (ph2_stb),
    .req_in  (req_raw),
    .req_out (req_al)
  );

  assign ready_sync = req_al[0];
  assign hold_sync  = req_al[1];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign group_oe[g] = !group_dis[g];
  end
endmodule

// File: rtl/cpu_bus_glue_chk.sv
module cpu_bus_glue_chk #(
  parameter int         DATA_W     = 8,
  parameter int         PORT_W     = 8,
  parameter logic [7:0] SENSE_PORT = 8'hFF,
  parameter int         NGRP       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int_n,
  input logic              ph1_stb,
  input logic              ph2_stb,
  input logic              cpu_sync,
  input logic              cpu_dbin,
  input logic              cpu_hlda,
  input logic [DATA_W-1:0] cpu_data,
  input logic [PORT_W-1:0] io_port,
  input logic              run_mode,
  input logic              step_mode,
  input logic [NGRP-1:0]   group_dis,
  input logic [DATA_W-1:0] status_q,
  input logic              din_en,
  input logic              ssw_dis,
  input logic              ready_sync,
  input logic              hold_sync,
  input logic [NGRP-1:0]   group_oe
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_sync && ph1_stb) |=> status_q == $past(cpu_data));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cpu_sync && ph1_stb) |=> $stable(status_q));

  a_r3_din_cond: assert property (@(posedge clk) disable iff (!rst_n)
    din_en |-> ((cpu_dbin || cpu_hlda) && (run_mode || step_mode) && !ssw_dis));

  a_r3_din_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_dbin || cpu_hlda) && (run_mode || step_mode) && !ssw_dis) |-> din_en);

  a_r4_ssw: assert property (@(posedge clk) disable iff (!rst_n)
    ssw_dis |-> (status_q[6] && io_port == PORT_W'(SENSE_PORT)));

  a_r6_req_still: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ph2_stb |=> ($stable(ready_sync) && $stable(hold_sync)));

  a_r7_groups: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(group_dis ^ group_oe) == NGRP);

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (status_q == '0 && !ready_sync && !hold_sync));
endmodule

bind cpu_bus_glue cpu_bus_glue_chk #(
  .DATA_W(DATA_W), .PORT_W(PORT_W), .SENSE_PORT(SENSE_PORT), .NGRP(cpu_glue_pkg::NUM_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n),
  .ph1_stb(ph1_stb), .ph2_stb(ph2_stb), .cpu_sync(cpu_sync),
  .cpu_dbin(cpu_dbin), .cpu_hlda(cpu_hlda), .cpu_data(cpu_data),
  .io_port(io_port), .run_mode(run_mode), .step_mode(step_mode),
  .group_dis(group_dis), .status_q(status_q), .din_en(din_en),
  .ssw_dis(ssw_dis), .ready_sync(ready_sync), .hold_sync(hold_sync),
  .group_oe(group_oe)
);

// File: tb/cpu_bus_glue_test.sv
`timescale 1ns/1ps
module cpu_bus_glue_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ph1_stb, ph2_stb, cpu_sync, cpu_dbin, cpu_hlda;
  logic [7:0] cpu_data, io_port;
  logic       run_mode, step_mode, ext_ready, ext_hold;
  logic [3:0] group_dis;
  logic [7:0] status_q;
  logic       din_en, ssw_dis, ready_sync, hold_sync;
  logic [3:0] group_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  cpu_bus_glue uut (
    .clk(clk), .rst_n(rst_n), .ph1_stb(ph1_stb), .ph2_stb(ph2_stb),
    .cpu_sync(cpu_sync), .cpu_dbin(cpu_dbin), .cpu_hlda(cpu_hlda),
    .cpu_data(cpu_data), .io_port(io_port), .run_mode(run_mode),
    .step_mode(step_mode), .ext_ready(ext_ready), .ext_hold(ext_hold),
    .group_dis(group_dis), .status_q(status_q), .din_en(din_en),
    .ssw_dis(ssw_dis), .ready_sync(ready_sync), .hold_sync(hold_sync),
    .group_oe(group_oe)
  );

  // Behavioural reference model
  logic [7:0] m_stat;
  logic       m_rdy, m_hld;
  logic [1:0] m_hist[$];
  int         m_rcnt;
  bit         m_capt, m_adv, m_inrst;

  always @(posedge clk) begin
    m_capt = 0;
    m_adv  = 0;
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      m_stat = '0; m_rdy = 0; m_hld = 0;
      m_hist = '{2'b00, 2'b00};
      m_inrst = 1;
    end else begin
      m_inrst = 0;
      if (cpu_sync && ph1_stb) begin m_stat = cpu_data; m_capt = 1; end
      if (ph2_stb) begin
        m_rdy = m_hist[$][0]; m_hld = m_hist[$][1]; m_adv = 1;
      end
      m_hist.push_front({ext_hold, ext_ready});
      void'(m_hist.pop_back());
    end
  end

  task automatic chk(string req, string nm, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_ssw, e_din;
    string rs, rq;
    e_ssw = m_stat[6] && (io_port == 8'hFF);
    e_din = (cpu_dbin || cpu_hlda) && (run_mode || step_mode) && !e_ssw;
    rs = m_inrst ? "R8" : (m_capt ? "R1" : "R2");
    rq = m_inrst ? "R8" : (m_adv ? "R5" : "R6");
    chk(rs, "status_q", status_q, m_stat);
    chk("R4", "ssw_dis", {7'd0, ssw_dis}, {7'd0, e_ssw});
    chk("R3", "din_en", {7'd0, din_en}, {7'd0, e_din});
    chk(rq, "ready_sync", {7'd0, ready_sync}, {7'd0, m_rdy});
    chk(rq, "hold_sync", {7'd0, hold_sync}, {7'd0, m_hld});
    chk("R7", "group_oe", {4'd0, group_oe}, {4'd0, ~group_dis});
  endtask

  task automatic drive(int k, bit wild);
    int r;
    r = $urandom_range(0, 99);
    ph1_stb  = wild ? ($urandom_range(0, 2) == 0) : (k % 4 == 0);
    ph2_stb  = wild ? ($urandom_range(0, 2) == 0) : (k % 4 == 2);
    cpu_sync = (r < 45);
    cpu_data = 8'($urandom);
    if ($urandom_range(0, 2) == 0) cpu_data[6] = 1'b1;
    io_port  = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
    cpu_dbin = $urandom_range(0, 1) == 1;
    cpu_hlda = $urandom_range(0, 3) == 0;
    run_mode = $urandom_range(0, 1) == 1;
    step_mode = $urandom_range(0, 3) == 0;
    if ($urandom_range(0, 4) == 0) ext_ready = ~ext_ready;
    if ($urandom_range(0, 5) == 0) ext_hold  = ~ext_hold;
    group_dis = 4'($urandom);
  endtask

  initial begin
    rst_n = 0; ext_ready = 0; ext_hold = 0;
    drive(0, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); compare_all(); drive(k, 0);   // R8 window
    end
    rst_n = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); compare_all(); drive(k, 0);
    end
    rst_n = 0;                                      // R8 mid-run reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); compare_all(); drive(k, 1);
    end
    rst_n = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); compare_all(); drive(k, 1);
    end
    // R4/R3 directed: capture an input status, then address the switch port
    cpu_sync = 1; ph1_stb = 1; ph2_stb = 0; cpu_data = 8'h42;
    cpu_dbin = 1; run_mode = 1; io_port = 8'hFF;
    @(negedge clk); compare_all();
    cpu_sync = 0; ph1_stb = 0; cpu_data = 8'h00;
    @(negedge clk); compare_all();
    chk("R4", "ssw_dis directed", {7'd0, ssw_dis}, 8'd1);
    chk("R3", "din_en directed", {7'd0, din_en}, 8'd0);
    io_port = 8'hFE;
    @(negedge clk); compare_all();
    chk("R3", "din_en other port", {7'd0, din_en}, 8'd1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule